// File: doc/BRIEF.md
# Skip-Pattern Rate Match FIFO

This block is an elastic buffer between the recovered receive clock and the local read clock of a serial receiver. It absorbs a small frequency offset between the two clocks, such as a few hundred parts per million either way. Words are two decoded code groups per clock. Each group is 9 bits: bit 8 is the control flag and bits 7:0 are the byte value. The upper group (bits 17:9) comes first on the line. The writer stores words only while the word-alignment lock input is high.

Compensation works on configured ordered sets. An opportunity word holds a control group in the upper half and its matching skip group in the lower half. Two such control/skip pairs can be set by parameter. When the buffer runs high, the write side drops a skip-pair word that directly follows an opportunity word. When it runs low, the read side emits an extra skip-pair word directly after an opportunity word. The configured skip groups should be neutral-disparity code groups, so that adding or removing them leaves running disparity unchanged.

Hard limits are handled as well. At full capacity, arriving words are discarded and a full flag is shown in the write domain. When the buffer is empty, a K30.7 filler pair is output with an empty flag in the same cycle. The two pointers cross the clock boundary as Gray codes.

Top module: `rate_match_fifo`

## Requirements
- R1: While `aligned` is low, no arriving word is stored, and the read side outputs the idle word {SKIP0,SKIP0} with `rd_empty` low.
- R2: With matched clock rates, every stored data word reaches `rd_word` once, in arrival order, with no filler.
- R3: After lock, the read side starts once its view of the occupancy reaches DEPTH/2. The first word it delivers is the first word written after lock.
- R4: A skip-pair word that does not follow an opportunity word triggers no compensation. An opportunity word has bits 17:9 equal to CTRLk and bits 8:0 equal to SKIPk.
- R5: At a write-side occupancy of DEPTH-4 or more, a word {SKIPk,SKIPk} that directly follows an opportunity word for pattern k is not stored. No data word is lost to this.
- R6: When the read side outputs an opportunity word while its occupancy is 4 or less, the next output word is an extra {SKIPk,SKIPk} and the read pointer holds for that cycle.
- R7: When the write-side occupancy reaches DEPTH, `wr_full` goes high and words arriving while full are discarded. Later words are still delivered in order.
- R8: When the read side finds the buffer empty, it outputs {9'h1FE,9'h1FE} with `rd_empty` high in the same cycle. No data word is lost.
- R9: Both patterns work independently. The skip pair that is inserted or deleted is always the skip group of the pattern that was detected.
- R10: After reset, `wr_full` and `rd_empty` are low and `rd_word` is the idle word {SKIP0,SKIP0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| aligned | input | 1 | Word-alignment lock, write domain |
| wr_word | input | 18 | Incoming word, two 9-bit groups, upper group first |
| wr_full | output | 1 | Buffer at capacity, arriving words dropped |
| rd_clk | input | 1 | Local read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_word | output | 18 | Outgoing word |
| rd_empty | output | 1 | High with each K30.7 filler pair |

## Verification
The assertions assume that both domain resets are held together for several cycles of each clock. They also assume that `aligned` stays low while the pointers restart, so the occupancy bounds hold from a shared zero. The bench meets this by dropping lock and asserting both resets over at least four edges of each clock before every scenario. It changes the clock periods only between scenarios, and it keeps each frequency offset within what one compensation word per four-word group can absorb.

// File: rtl/rmf_pkg.sv
`timescale 1ns/1ps
package rmf_pkg;
    localparam int GRP_W  = 9;
    localparam int WORD_W = 2 * GRP_W;

    typedef logic [GRP_W-1:0]  grp_t;
    typedef logic [WORD_W-1:0] word_t;

    // K30.7 with the control flag set
    localparam grp_t FILL_GRP = 9'h1FE;

    typedef struct packed {
        logic  opp;   // entry is a control/skip opportunity word
        word_t word;
    } entry_t;
endpackage

// File: rtl/rmf_sync.sv
`timescale 1ns/1ps
module rmf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q = s_q.s2;
endmodule

// File: rtl/rmf_mem.sv
`timescale 1ns/1ps
module rmf_mem
    import rmf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  entry_t            wdata,
    input  logic [ADDR_W-1:0] raddr,
    output entry_t            rdata
);
    entry_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rmf_wr.sv
`timescale 1ns/1ps
module rmf_wr
    import rmf_pkg::*;
#(
    parameter int   DEPTH  = 16,
    parameter int   ADDR_W = 4,
    parameter int   PTR_W  = 5,
    parameter int   HI_MK  = 12,
    parameter grp_t CTRL0  = 9'h1BC,
    parameter grp_t SKIP0  = 9'h11C,
    parameter grp_t CTRL1  = 9'h13C,
    parameter grp_t SKIP1  = 9'h1F7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  word_t             din,
    input  logic [PTR_W-1:0]  rgray_sync,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output entry_t            wdata,
    output logic [PTR_W-1:0]  wgray,
    output logic [PTR_W-1:0]  level,
    output logic              full
);
    localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HI  = PTR_W'(HI_MK);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] gray;
        logic             opp;   // previous word was an opportunity word
        logic             sel;   // which pattern it matched
        logic             full;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [PTR_W-1:0] to_bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] lvl;
    logic             hit0, hit1, drop_skip, at_cap, wr_go;
    grp_t             skip_k;

    always_comb begin
        lvl       = s_q.ptr - to_bin(rgray_sync);
        hit0      = (din == {CTRL0, SKIP0});
        hit1      = (din == {CTRL1, SKIP1});
        skip_k    = s_q.sel ? SKIP1 : SKIP0;
        at_cap    = (lvl == CAP);
        drop_skip = lock && s_q.opp && (din == {skip_k, skip_k}) && (lvl >= HI);
        wr_go     = lock && !drop_skip && !at_cap;

        s_d      = s_q;
        s_d.ptr  = s_q.ptr + PTR_W'(wr_go);
        s_d.gray = s_d.ptr ^ (s_d.ptr >> 1);
        s_d.opp  = lock && (hit0 || hit1);
        s_d.sel  = hit1;
        s_d.full = lock && ((lvl + PTR_W'(wr_go)) == CAP);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign we    = wr_go;
    assign waddr = s_q.ptr[ADDR_W-1:0];
    assign wdata = '{opp: hit0 || hit1, word: din};
    assign wgray = s_q.gray;
    assign level = lvl;
    assign full  = s_q.full;
endmodule

// File: rtl/rmf_rd.sv
`timescale 1ns/1ps
module rmf_rd
    import rmf_pkg::*;
#(
    parameter int   ADDR_W = 4,
    parameter int   PTR_W  = 5,
    parameter int   LO_MK  = 4,
    parameter int   GO_MK  = 8,
    parameter grp_t SKIP0  = 9'h11C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic [PTR_W-1:0]  wgray_sync,
    output logic [ADDR_W-1:0] raddr,
    input  entry_t            rdata,
    output logic [PTR_W-1:0]  rgray,
    output logic [PTR_W-1:0]  level,
    output word_t             dout,
    output logic              empty
);
    localparam logic [PTR_W-1:0] LO   = PTR_W'(LO_MK);
    localparam logic [PTR_W-1:0] GO   = PTR_W'(GO_MK);
    localparam word_t            IDLE = {SKIP0, SKIP0};
    localparam word_t            FILL = {FILL_GRP, FILL_GRP};

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] gray;
        logic             run;
        logic             ins;
        grp_t             ins_grp;
        word_t            dout;
        logic             empty;
    } st_t;

    localparam st_t RST_ST = '{ptr: '0, gray: '0, run: 1'b0, ins: 1'b0,
                               ins_grp: SKIP0, dout: IDLE, empty: 1'b0};

    st_t s_d, s_q;

    function automatic logic [PTR_W-1:0] to_bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] lvl;

    always_comb begin
        lvl       = to_bin(wgray_sync) - s_q.ptr;
        s_d       = s_q;
        s_d.empty = 1'b0;
        s_d.ins   = 1'b0;
        if (!lock) begin
            s_d.run  = 1'b0;
            s_d.dout = IDLE;
        end else if (!s_q.run) begin
            s_d.run  = (lvl >= GO);
            s_d.dout = IDLE;
        end else if (s_q.ins) begin
            s_d.dout = {s_q.ins_grp, s_q.ins_grp};
        end else if (lvl == '0) begin
            s_d.dout  = FILL;
            s_d.empty = 1'b1;
        end else begin
            s_d.dout = rdata.word;
            s_d.ptr  = s_q.ptr + 1'b1;
            if (rdata.opp && (lvl <= LO)) begin
                s_d.ins     = 1'b1;
                s_d.ins_grp = rdata.word[GRP_W-1:0];
            end
        end
        s_d.gray = s_d.ptr ^ (s_d.ptr >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= RST_ST;
        else     s_q <= s_d;
    end

    assign raddr = s_q.ptr[ADDR_W-1:0];
    assign rgray = s_q.gray;
    assign level = lvl;
    assign dout  = s_q.dout;
    assign empty = s_q.empty;
endmodule

// File: rtl/rate_match_fifo.sv
`timescale 1ns/1ps
module rate_match_fifo
    import rmf_pkg::*;
#(
    parameter int   DEPTH = 16,
    parameter grp_t CTRL0 = 9'h1BC,
    parameter grp_t SKIP0 = 9'h11C,
    parameter grp_t CTRL1 = 9'h13C,
    parameter grp_t SKIP1 = 9'h1F7
) (
    input  logic        wr_clk,
    input  logic        wr_rst,
    input  logic        aligned,
    input  logic [17:0] wr_word,
    output logic        wr_full,
    input  logic        rd_clk,
    input  logic        rd_rst,
    output logic [17:0] rd_word,
    output logic        rd_empty
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam int HI_MK  = DEPTH - 4;
    localparam int LO_MK  = 4;
    localparam int GO_MK  = DEPTH / 2;

    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    entry_t            wdata, rdata;
    logic [PTR_W-1:0]  wgray, wgray_rd, rgray, rgray_wr;
    logic [PTR_W-1:0]  wr_level, rd_level;
    logic              lock_rd;

    rmf_wr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .HI_MK(HI_MK),
             .CTRL0(CTRL0), .SKIP0(SKIP0), .CTRL1(CTRL1), .SKIP1(SKIP1)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .lock(aligned), .din(wr_word),
        .rgray_sync(rgray_wr), .we(we), .waddr(waddr), .wdata(wdata),
        .wgray(wgray), .level(wr_level), .full(wr_full)
    );

    rmf_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    rmf_sync #(.W(PTR_W)) u_wsync (.clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_rd));
    rmf_sync #(.W(PTR_W)) u_rsync (.clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_wr));
    rmf_sync #(.W(1))     u_lsync (.clk(rd_clk), .rst(rd_rst), .d(aligned), .q(lock_rd));

    rmf_rd #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LO_MK(LO_MK), .GO_MK(GO_MK),
             .SKIP0(SKIP0)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .lock(lock_rd), .wgray_sync(wgray_rd),
        .raddr(raddr), .rdata(rdata), .rgray(rgray), .level(rd_level),
        .dout(rd_word), .empty(rd_empty)
    );
endmodule

// File: rtl/rmf_checker.sv
`timescale 1ns/1ps
module rmf_checker #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 5
) (
    input logic             wr_clk,
    input logic             wr_rst,
    input logic             rd_clk,
    input logic             rd_rst,
    input logic             aligned,
    input logic [PTR_W-1:0] wr_level,
    input logic [PTR_W-1:0] rd_level,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rgray,
    input logic [17:0]      rd_word,
    input logic             rd_empty
);
    a_r7_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_level <= PTR_W'(DEPTH));

    a_r2_rd_level_bound: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_level <= PTR_W'(DEPTH));

    a_r1_hold_unlocked: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !aligned |=> $stable(wgray));

    a_r2_wgray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r2_rgray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1);

    a_r8_filler_with_flag: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_empty |-> (rd_word == 18'h3FDFE));
endmodule

bind rate_match_fifo rmf_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .aligned(aligned), .wr_level(wr_level), .rd_level(rd_level),
    .wgray(wgray), .rgray(rgray), .rd_word(rd_word), .rd_empty(rd_empty)
);

// File: tb/rate_match_fifo_test.sv
`timescale 1ns/1ps
module rate_match_fifo_test;
    localparam logic [8:0]  CTRL0 = 9'h1BC, SKIP0 = 9'h11C;
    localparam logic [8:0]  CTRL1 = 9'h13C, SKIP1 = 9'h1F7;
    localparam logic [17:0] FILL  = {9'h1FE, 9'h1FE};
    localparam logic [17:0] IDLE  = {SKIP0, SKIP0};

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1, aligned = 1'b0;
    logic [17:0] wr_word = '0;
    logic [17:0] rd_word;
    logic        wr_full, rd_empty;
    real         wr_half = 10.0, rd_half = 10.0;

    always #(wr_half) wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    rate_match_fifo #(.DEPTH(16), .CTRL0(CTRL0), .SKIP0(SKIP0),
                      .CTRL1(CTRL1), .SKIP1(SKIP1)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .aligned(aligned), .wr_word(wr_word),
        .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_word(rd_word), .rd_empty(rd_empty)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    bit mon_on = 0, have_first = 0;
    int seen_data, gaps, order_bad, fillers, empty_seen, empty_bad;
    int ss0_out, ss1_out, opp0_out, opp1_out, other_out, idle_out, full_seen;
    int first_seq, last_seq, mon_seq, ss_sent;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(negedge rd_clk) if (mon_on) begin
        if (rd_empty) begin
            empty_seen++;
            if (rd_word != FILL) empty_bad++;
        end
        if (rd_word == FILL) fillers++;
        else if (!rd_word[17] && !rd_word[8]) begin
            mon_seq = {16'd0, rd_word[16:9], rd_word[7:0]};
            if (!have_first) begin
                first_seq  = mon_seq;
                have_first = 1;
            end else if (mon_seq > last_seq + 1) gaps++;
            else if (mon_seq != last_seq + 1) order_bad++;
            last_seq = mon_seq;
            seen_data++;
        end
        else if (!have_first && rd_word == IDLE) idle_out++;
        else if (rd_word == IDLE) ss0_out++;
        else if (rd_word == {SKIP1, SKIP1}) ss1_out++;
        else if (rd_word == {CTRL0, SKIP0}) opp0_out++;
        else if (rd_word == {CTRL1, SKIP1}) opp1_out++;
        else other_out++;
    end

    always @(negedge wr_clk) if (mon_on && wr_full) full_seen++;

    task automatic reset_all(input real wh, input real rh);
        mon_on  = 0;
        aligned = 1'b0;
        wr_half = wh;
        rd_half = rh;
        wr_rst  = 1'b1;
        rd_rst  = 1'b1;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        have_first = 0;
        seen_data = 0; gaps = 0; order_bad = 0; fillers = 0;
        empty_seen = 0; empty_bad = 0; ss0_out = 0; ss1_out = 0;
        opp0_out = 0; opp1_out = 0; other_out = 0; idle_out = 0;
        full_seen = 0; first_seq = -1; last_seq = 0; ss_sent = 0;
        mon_on = 1;
    endtask

    // mode 0: data only; 1/2: opportunity word for pattern 0/1 then its skip pair;
    // 3: lone {SKIP0,SKIP0} without a control group before it
    task automatic stream(input int n, input int mode);
        logic [15:0] seq = 16'd0;
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            aligned = 1'b1;
            if ((mode == 1 || mode == 2) && (i % 4) == 0)
                wr_word = (mode == 1) ? {CTRL0, SKIP0} : {CTRL1, SKIP1};
            else if ((mode == 1 || mode == 2) && (i % 4) == 1) begin
                wr_word = (mode == 1) ? {SKIP0, SKIP0} : {SKIP1, SKIP1};
                ss_sent++;
            end else if (mode == 3 && (i % 4) == 1) begin
                wr_word = {SKIP0, SKIP0};
                ss_sent++;
            end else begin
                wr_word = {1'b0, seq[15:8], 1'b0, seq[7:0]};
                seq++;
            end
        end
        @(negedge rd_clk);
        mon_on = 0;
    endtask

    task automatic t_reset();
        reset_all(10.0, 10.0);
        @(negedge rd_clk);
        check(rd_word == IDLE, "R10", "idle word after reset", int'(rd_word), int'(IDLE));
        check(rd_empty == 1'b0, "R10", "empty flag after reset", int'(rd_empty), 0);
        check(wr_full == 1'b0, "R10", "full flag after reset", int'(wr_full), 0);
    endtask

    task automatic t_unlocked();
        reset_all(10.0, 10.0);
        for (int i = 0; i < 50; i++) begin
            @(negedge wr_clk);
            aligned = 1'b0;
            wr_word = {1'b0, 8'h03, 1'b0, 8'(i)};
        end
        check(seen_data == 0, "R1", "data out while unlocked", seen_data, 0);
        check(idle_out > 40, "R1", "idle words while unlocked", idle_out, 41);
        check(empty_seen == 0, "R1", "empty flag while unlocked", empty_seen, 0);
        stream(60, 0);
        check(first_seq == 0, "R3", "first delivered word", first_seq, 0);
        check(seen_data > 40, "R3", "words delivered after start", seen_data, 41);
    endtask

    task automatic t_match();
        reset_all(10.0, 10.0);
        stream(300, 0);
        check(gaps == 0, "R2", "gaps at matched rate", gaps, 0);
        check(order_bad == 0, "R2", "order errors at matched rate", order_bad, 0);
        check(fillers == 0, "R2", "fillers at matched rate", fillers, 0);
        check(full_seen == 0, "R2", "full at matched rate", full_seen, 0);
        check(seen_data >= 276, "R2", "words delivered", seen_data, 276);
    endtask

    task automatic t_full();
        reset_all(10.0, 11.5);
        stream(400, 0);
        check(full_seen > 0, "R7", "full flag seen", full_seen, 1);
        check(gaps > 0, "R7", "discarded words", gaps, 1);
        check(order_bad == 0, "R7", "order after overflow", order_bad, 0);
        check(seen_data > 200, "R7", "words delivered after overflow", seen_data, 201);
    endtask

    task automatic t_empty();
        reset_all(10.0, 8.5);
        stream(400, 0);
        check(empty_seen > 0, "R8", "empty flag seen", empty_seen, 1);
        check(empty_bad == 0, "R8", "flag without filler pair", empty_bad, 0);
        check(fillers == empty_seen, "R8", "fillers vs flags", fillers, empty_seen);
        check(gaps == 0, "R8", "data lost on underflow", gaps, 0);
        check(seen_data >= 376, "R8", "words delivered", seen_data, 376);
    endtask

    task automatic t_delete();
        reset_all(10.0, 10.5);
        stream(600, 1);
        check(full_seen == 0, "R5", "full flag with deletion", full_seen, 0);
        check(gaps == 0, "R5", "data lost with deletion", gaps, 0);
        check(opp0_out - ss0_out >= 5, "R5", "skip pairs removed", opp0_out - ss0_out, 5);
        check(ss1_out == 0 && other_out == 0, "R9", "foreign words in pattern 0 run",
              ss1_out + other_out, 0);
    endtask

    task automatic t_insert();
        reset_all(10.0, 9.0);
        stream(600, 2);
        check(empty_seen == 0, "R6", "empty flag with insertion", empty_seen, 0);
        check(gaps == 0, "R6", "data lost with insertion", gaps, 0);
        check(ss1_out - opp1_out >= 5, "R6", "skip pairs added", ss1_out - opp1_out, 5);
        check(ss0_out == 0 && other_out == 0, "R9", "foreign words in pattern 1 run",
              ss0_out + other_out, 0);
    endtask

    task automatic t_lone_skip();
        reset_all(10.0, 8.5);
        stream(400, 3);
        check(empty_seen > 0, "R4", "underflow with lone skip pairs", empty_seen, 1);
        check(ss0_out <= ss_sent, "R4", "lone skip pairs not duplicated", ss0_out, ss_sent);
        check(gaps == 0, "R4", "data lost with lone skip pairs", gaps, 0);
    endtask

    initial begin
        #3_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        t_reset();
        t_unlocked();
        t_match();
        t_full();
        t_empty();
        t_delete();
        t_insert();
        t_lone_skip();
        finish_up();
    end
endmodule